// File: doc/BRIEF.md
# Power Domain Sequencing Controller

This block switches a set of power domains on and off under software control. Each domain has its own 128-byte register window on a simple register bus. Software writes a target state into the domain's command register. A per-domain sequencer then walks the domain through four ordered steps on its control outputs: clock enable, reset, isolation clamp and power switch. It waits a programmable number of core clock cycles after each step. The switch step also waits for the switch acknowledge input to match the commanded switch level.

While a transition runs, the status register shows a busy flag. When the transition ends, the state field shows the new state, and one cycle later a sticky completion flag sets. Software clears that flag by writing a one to its bit. Driver code can therefore poll for busy to clear, issue a command, and then poll for completion. The domains are independent of one another, and any number of them may be sequencing at the same time.

Top module: `pdc_top`

## Requirements
- R1: Domain i's registers occupy byte addresses i*0x80 to i*0x80+0x7F. Within a window, the delay registers sit at offset 0x14 (step delay), 0x18 (power-down settle delay) and 0x1C (power-up settle delay). Each holds DLY_W bits, and writes keep only the low DLY_W bits. All other offsets, offset 0x20 and any address beyond the last domain read as zero.
- R2: After reset, every domain reads state 1 (on) with busy and completion clear, so status is 0x0001_0000. Every delay register reads RST_DLY. The outputs are rst_n=1, clk_en=1, iso=0 and pwr_sw=1.
- R3: Writing 2 to offset 0x20 of a domain that is on starts power-down, which sets status bit 3 (busy). The outputs change in the order clk_en low, then rst_n low, then iso high, then pwr_sw low. While pwr_sw is low, iso is high and rst_n and clk_en are low.
- R4: Writing 1 to offset 0x20 of a domain that is off starts power-up. The outputs change in the order pwr_sw high, then iso low, then rst_n high, then clk_en high. clk_en is high only while rst_n=1, iso=0 and pwr_sw=1.
- R5: A delay value d waits d+1 cycles, so 0 means one cycle. With S the step delay, power-down clears busy 3S+F+10 cycles after the command edge, where F is the power-down settle delay. Power-up clears busy after 3S+N+10 cycles, where N is the power-up settle delay. Busy always falls together with completion rising.
- R6: After driving the switch, the sequencer holds until sw_ack equals pwr_sw. It then waits the rest of its delays, which finish 5 cycles after the match when the settle delay is 2.
- R7: Status bits 17:16 take the new state (1 on, 2 off) one cycle before status bit 1 (completion) sets. Busy is clear once completion is set.
- R8: A status write with bit 1 set clears completion. A status write with bit 1 clear leaves it set.
- R9: A command is ignored if it arrives while busy, if it carries a value other than 1 or 2, or if it names the state the domain is already in.
- R10: Offset 0x30 reads bit 0 = rst_n, bit 1 = clk_en and bit 2 = iso. Offset 0x34 bit 0 reads sw_ack.
- R11: A transition in one domain leaves the outputs and status of the other domains unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_en | input | 1 | Write strobe for the addressed register |
| bus_addr | input | ADDR_W | Byte address; upper bits select the domain |
| bus_wdata | input | 32 | Write data |
| bus_rd_data | output | 32 | Read data of the addressed register (combinational) |
| sw_ack | input | NUM_DOM | Per-domain power switch acknowledge |
| dom_rst_n | output | NUM_DOM | Per-domain reset, active low |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_iso | output | NUM_DOM | Per-domain isolation clamp, active high |
| dom_pwr_sw | output | NUM_DOM | Per-domain power switch, 1 = closed |

## Verification
The bench times each transition exactly against the delay formula. A sequencer that miscounted a delay by one, or that used the wrong delay register for the settle wait, would finish early or late. The bench records when each control output first changes and checks the order. A swapped pair of steps would let clocks run into an isolated or unpowered domain. It holds the switch acknowledge back and expects the sequence to stall, then checks that it ends exactly five cycles after the release. It also issues a second command in the middle of a transition, invalid codes and a command for the state already held. A design that restarted on any of these would show a different finish time, a set busy flag, or completion reported without a transition.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int WIN_BITS = 7;

  localparam logic [WIN_BITS-1:0] OFF_STEP_DLY = 7'h14;
  localparam logic [WIN_BITS-1:0] OFF_DOWN_DLY = 7'h18;
  localparam logic [WIN_BITS-1:0] OFF_UP_DLY   = 7'h1C;
  localparam logic [WIN_BITS-1:0] OFF_CMD      = 7'h20;
  localparam logic [WIN_BITS-1:0] OFF_STAT     = 7'h24;
  localparam logic [WIN_BITS-1:0] OFF_GATES    = 7'h30;
  localparam logic [WIN_BITS-1:0] OFF_SWITCH   = 7'h34;

  localparam logic [1:0] PWR_ON  = 2'd1;
  localparam logic [1:0] PWR_OFF = 2'd2;

  localparam int STAT_DONE_BIT  = 1;
  localparam int STAT_BUSY_BIT  = 3;
  localparam int STAT_STATE_LSB = 16;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_ACT,
    SQ_ACK,
    SQ_WAIT,
    SQ_FIN
  } seq_state_e;
endpackage

// File: rtl/pdc_rst_sync.sv
module pdc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pdc_addr_dec.sv
module pdc_addr_dec import pdc_pkg::*; #(
  parameter int NUM_DOM  = 3,
  parameter int DOM_BITS = 2,
  localparam int ADDR_W  = DOM_BITS + WIN_BITS
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic [NUM_DOM-1:0]  dom_sel,
  output logic [WIN_BITS-1:0] win_off
);
  assign win_off = addr[WIN_BITS-1:0];

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_sel
    assign dom_sel[i] = (addr[ADDR_W-1:WIN_BITS] == DOM_BITS'(i));
  end
endmodule

// File: rtl/pdc_domain_seq.sv
module pdc_domain_seq import pdc_pkg::*; #(
  parameter int DLY_W   = 8,
  parameter int RST_DLY = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [WIN_BITS-1:0] win_off,
  input  logic [31:0]         wdata,
  input  logic                sw_ack,
  output logic [31:0]         rd_data,
  output logic                dom_rst_n,
  output logic                dom_clk_en,
  output logic                dom_iso,
  output logic                dom_pwr_sw,
  output logic                busy,
  output logic                done,
  output logic [1:0]          cur_state
);
  localparam logic [DLY_W-1:0] DLY_INIT  = DLY_W'(RST_DLY);
  localparam logic [1:0]       LAST_STEP = 2'd3;

  // configuration
  logic [DLY_W-1:0] step_dly_q, down_dly_q, up_dly_q;
  logic             wr_step, wr_down, wr_up, wr_cmd, wr_stat;

  // sequencer
  seq_state_e       seq_q, seq_d;
  logic [1:0]       step_q, step_d;
  logic             going_down_q, going_down_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic [1:0]       pwr_q, pwr_d;
  logic             busy_q, busy_d, done_q, done_d;
  logic             rstn_q, rstn_d, clken_q, clken_d, iso_q, iso_d, sw_q, sw_d;
  logic [DLY_W-1:0] wait_len;
  logic             switch_step;

  assign wr_step = wr_en && (win_off == OFF_STEP_DLY);
  assign wr_down = wr_en && (win_off == OFF_DOWN_DLY);
  assign wr_up   = wr_en && (win_off == OFF_UP_DLY);
  assign wr_cmd  = wr_en && (win_off == OFF_CMD);
  assign wr_stat = wr_en && (win_off == OFF_STAT);

  always_comb begin
    if (step_q == LAST_STEP) wait_len = going_down_q ? down_dly_q : up_dly_q;
    else                     wait_len = step_dly_q;
    switch_step = going_down_q ? (step_q == LAST_STEP) : (step_q == 2'd0);
  end

  always_comb begin
    seq_d        = seq_q;
    step_d       = step_q;
    going_down_d = going_down_q;
    cnt_d        = cnt_q;
    pwr_d        = pwr_q;
    busy_d       = busy_q;
    done_d       = done_q;
    rstn_d       = rstn_q;
    clken_d      = clken_q;
    iso_d        = iso_q;
    sw_d         = sw_q;

    if (wr_stat && wdata[STAT_DONE_BIT]) done_d = 1'b0;

    unique case (seq_q)
      SQ_IDLE: begin
        if (wr_cmd && !busy_q) begin
          if (wdata == 32'(PWR_OFF) && pwr_q == PWR_ON) begin
            going_down_d = 1'b1;
            seq_d        = SQ_ACT;
            step_d       = 2'd0;
            busy_d       = 1'b1;
          end else if (wdata == 32'(PWR_ON) && pwr_q == PWR_OFF) begin
            going_down_d = 1'b0;
            seq_d        = SQ_ACT;
            step_d       = 2'd0;
            busy_d       = 1'b1;
          end
        end
      end
      SQ_ACT: begin
        unique case ({going_down_q, step_q})
          3'b1_00: clken_d = 1'b0;
          3'b1_01: rstn_d  = 1'b0;
          3'b1_10: iso_d   = 1'b1;
          3'b1_11: sw_d    = 1'b0;
          3'b0_00: sw_d    = 1'b1;
          3'b0_01: iso_d   = 1'b0;
          3'b0_10: rstn_d  = 1'b1;
          3'b0_11: clken_d = 1'b1;
          default: ;
        endcase
        if (switch_step) begin
          seq_d = SQ_ACK;
        end else begin
          seq_d = SQ_WAIT;
          cnt_d = wait_len;
        end
      end
      SQ_ACK: begin
        if (sw_ack == sw_q) begin
          seq_d = SQ_WAIT;
          cnt_d = wait_len;
        end
      end
      SQ_WAIT: begin
        if (cnt_q == '0) begin
          if (step_q == LAST_STEP) begin
            seq_d = SQ_FIN;
            pwr_d = going_down_q ? PWR_OFF : PWR_ON;
          end else begin
            step_d = step_q + 2'd1;
            seq_d  = SQ_ACT;
          end
        end else begin
          cnt_d = cnt_q - DLY_W'(1);
        end
      end
      SQ_FIN: begin
        seq_d  = SQ_IDLE;
        busy_d = 1'b0;
        done_d = 1'b1;
      end
      default: seq_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_dly_q <= DLY_INIT;
      down_dly_q <= DLY_INIT;
      up_dly_q   <= DLY_INIT;
    end else begin
      if (wr_step) step_dly_q <= wdata[DLY_W-1:0];
      if (wr_down) down_dly_q <= wdata[DLY_W-1:0];
      if (wr_up)   up_dly_q   <= wdata[DLY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_q        <= SQ_IDLE;
      step_q       <= 2'd0;
      going_down_q <= 1'b0;
      cnt_q        <= '0;
      pwr_q        <= PWR_ON;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      rstn_q       <= 1'b1;
      clken_q      <= 1'b1;
      iso_q        <= 1'b0;
      sw_q         <= 1'b1;
    end else begin
      seq_q        <= seq_d;
      step_q       <= step_d;
      going_down_q <= going_down_d;
      cnt_q        <= cnt_d;
      pwr_q        <= pwr_d;
      busy_q       <= busy_d;
      done_q       <= done_d;
      rstn_q       <= rstn_d;
      clken_q      <= clken_d;
      iso_q        <= iso_d;
      sw_q         <= sw_d;
    end
  end

  always_comb begin
    rd_data = '0;
    unique case (win_off)
      OFF_STEP_DLY: rd_data[DLY_W-1:0] = step_dly_q;
      OFF_DOWN_DLY: rd_data[DLY_W-1:0] = down_dly_q;
      OFF_UP_DLY:   rd_data[DLY_W-1:0] = up_dly_q;
      OFF_STAT: begin
        rd_data[STAT_STATE_LSB +: 2] = pwr_q;
        rd_data[STAT_BUSY_BIT]       = busy_q;
        rd_data[STAT_DONE_BIT]       = done_q;
      end
      OFF_GATES:  rd_data[2:0] = {iso_q, clken_q, rstn_q};
      OFF_SWITCH: rd_data[0]   = sw_ack;
      default: ;
    endcase
  end

  assign dom_rst_n  = rstn_q;
  assign dom_clk_en = clken_q;
  assign dom_iso    = iso_q;
  assign dom_pwr_sw = sw_q;
  assign busy       = busy_q;
  assign done       = done_q;
  assign cur_state  = pwr_q;
endmodule

// File: rtl/pdc_top.sv
module pdc_top import pdc_pkg::*; #(
  parameter int NUM_DOM  = 3,
  parameter int DLY_W    = 8,
  parameter int RST_DLY  = 2,
  localparam int DOM_BITS = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1,
  localparam int ADDR_W   = DOM_BITS + WIN_BITS
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr_en,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rd_data,
  input  logic [NUM_DOM-1:0] sw_ack,
  output logic [NUM_DOM-1:0] dom_rst_n,
  output logic [NUM_DOM-1:0] dom_clk_en,
  output logic [NUM_DOM-1:0] dom_iso,
  output logic [NUM_DOM-1:0] dom_pwr_sw
);
  logic                   rst_core_n;
  logic [NUM_DOM-1:0]     dom_sel;
  logic [WIN_BITS-1:0]    win_off;
  logic [31:0]            rd_vec [NUM_DOM];
  logic [NUM_DOM-1:0]     dom_busy;
  logic [NUM_DOM-1:0]     dom_done;
  logic [2*NUM_DOM-1:0]   dom_state_flat;

  pdc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  pdc_addr_dec #(.NUM_DOM(NUM_DOM), .DOM_BITS(DOM_BITS)) u_dec (
    .addr    (bus_addr),
    .dom_sel (dom_sel),
    .win_off (win_off)
  );

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    pdc_domain_seq #(.DLY_W(DLY_W), .RST_DLY(RST_DLY)) u_seq (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .wr_en      (bus_wr_en & dom_sel[i]),
      .win_off    (win_off),
      .wdata      (bus_wdata),
      .sw_ack     (sw_ack[i]),
      .rd_data    (rd_vec[i]),
      .dom_rst_n  (dom_rst_n[i]),
      .dom_clk_en (dom_clk_en[i]),
      .dom_iso    (dom_iso[i]),
      .dom_pwr_sw (dom_pwr_sw[i]),
      .busy       (dom_busy[i]),
      .done       (dom_done[i]),
      .cur_state  (dom_state_flat[2*i +: 2])
    );
  end

  always_comb begin
    bus_rd_data = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (dom_sel[i]) bus_rd_data = bus_rd_data | rd_vec[i];
    end
  end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker #(
  parameter int NUM_DOM = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_DOM-1:0]   dom_rst_n,
  input logic [NUM_DOM-1:0]   dom_clk_en,
  input logic [NUM_DOM-1:0]   dom_iso,
  input logic [NUM_DOM-1:0]   dom_pwr_sw,
  input logic [NUM_DOM-1:0]   dom_busy,
  input logic [NUM_DOM-1:0]   dom_done,
  input logic [2*NUM_DOM-1:0] dom_state_flat
);
  for (genvar g = 0; g < NUM_DOM; g++) begin : g_chk
    // R3: an open switch always sees the domain clamped, held in reset and unclocked
    p_sw_open_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_pwr_sw[g] |-> (dom_iso[g] && !dom_rst_n[g] && !dom_clk_en[g]));

    // R4: the clock only runs into a live, released, unclamped domain
    p_clk_needs_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dom_clk_en[g] |-> (dom_rst_n[g] && !dom_iso[g] && dom_pwr_sw[g]));

    // R5: busy ends exactly when completion is reported
    p_busy_end_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_busy[g]) |-> dom_done[g]);

    // R7: completion rises with busy clear and the state field already settled
    p_done_state_settled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_done[g]) |-> (!dom_busy[g] && $stable(dom_state_flat[2*g +: 2])));

    // R9: the state field moves only inside a running transition
    p_state_move_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_state_flat[2*g +: 2] != $past(dom_state_flat[2*g +: 2]))
        |-> ($past(dom_busy[g]) && dom_busy[g]));
  end
endmodule

bind pdc_top pdc_checker #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .dom_rst_n      (dom_rst_n),
  .dom_clk_en     (dom_clk_en),
  .dom_iso        (dom_iso),
  .dom_pwr_sw     (dom_pwr_sw),
  .dom_busy       (dom_busy),
  .dom_done       (dom_done),
  .dom_state_flat (dom_state_flat)
);

// File: tb/sim_pdc_top.sv
`timescale 1ns/1ps
module sim_pdc_top;
  localparam int ND = 3;
  localparam int AW = 9;

  logic          clk, rst_n, bus_wr_en;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata, bus_rd_data;
  logic [ND-1:0] sw_ack, dom_rst_n, dom_clk_en, dom_iso, dom_pwr_sw;
  logic [ND-1:0] ack_frz, ack_val;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  assign sw_ack = (ack_frz & ack_val) | (~ack_frz & dom_pwr_sw);

  pdc_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rd_data(bus_rd_data), .sw_ack(sw_ack),
    .dom_rst_n(dom_rst_n), .dom_clk_en(dom_clk_en), .dom_iso(dom_iso),
    .dom_pwr_sw(dom_pwr_sw)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {req[3:0], write, addr[8:0], wdata[31:0], expected[31:0]}
  localparam int NV = 15;
  localparam logic [77:0] VEC [NV] = '{
    {4'd2,  1'b0, 9'h024, 32'h0, 32'h0001_0000}, // R2 status after reset
    {4'd2,  1'b0, 9'h014, 32'h0, 32'h0000_0002}, // R2 step delay
    {4'd2,  1'b0, 9'h118, 32'h0, 32'h0000_0002}, // R2 down delay, domain 2
    {4'd10, 1'b0, 9'h030, 32'h0, 32'h0000_0003}, // R10 gates
    {4'd10, 1'b0, 9'h034, 32'h0, 32'h0000_0001}, // R10 switch ack
    {4'd1,  1'b1, 9'h094, 32'h5, 32'h0},
    {4'd1,  1'b0, 9'h094, 32'h0, 32'h0000_0005}, // R1 domain 1 window
    {4'd1,  1'b0, 9'h014, 32'h0, 32'h0000_0002}, // R1 domain 0 untouched
    {4'd1,  1'b1, 9'h11C, 32'h1FF, 32'h0},
    {4'd1,  1'b0, 9'h11C, 32'h0, 32'h0000_00FF}, // R1 truncation
    {4'd1,  1'b1, 9'h11C, 32'h2, 32'h0},
    {4'd1,  1'b0, 9'h000, 32'h0, 32'h0},          // R1 unused offset
    {4'd1,  1'b0, 9'h120, 32'h0, 32'h0},          // R1 command reads zero
    {4'd1,  1'b0, 9'h180, 32'h0, 32'h0},          // R1 beyond last domain
    {4'd2,  1'b0, 9'h0A4, 32'h0, 32'h0001_0000}   // R2 domain 1 status
  };

  function automatic logic [AW-1:0] ad(input int dom, input int off);
    return AW'(dom * 128 + off);
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(tag, bus_rd_data, exp);
  endtask

  function automatic logic [3:0] pins(input int d);
    return {dom_pwr_sw[d], dom_iso[d], dom_clk_en[d], dom_rst_n[d]};
  endfunction

  // polls status busy of a domain; records first change of each output
  task automatic poll(input int dom, input int start, input int limit, output int n,
                      output int t_clk, output int t_rst, output int t_iso, output int t_sw);
    logic c0, r0, i0, s0;
    c0 = dom_clk_en[dom]; r0 = dom_rst_n[dom]; i0 = dom_iso[dom]; s0 = dom_pwr_sw[dom];
    t_clk = 0; t_rst = 0; t_iso = 0; t_sw = 0;
    bus_addr = ad(dom, 'h24);
    n = start;
    do begin
      @(negedge clk);
      #1;
      n++;
      if (t_clk == 0 && dom_clk_en[dom] != c0) t_clk = n;
      if (t_rst == 0 && dom_rst_n[dom]  != r0) t_rst = n;
      if (t_iso == 0 && dom_iso[dom]    != i0) t_iso = n;
      if (t_sw  == 0 && dom_pwr_sw[dom] != s0) t_sw  = n;
    end while (bus_rd_data[3] && n < limit);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n, tc, tr, ti, ts;
    rst_n = 1'b0; bus_wr_en = 1'b0; bus_addr = '0; bus_wdata = '0;
    ack_frz = '0; ack_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset pins
    for (int d = 0; d < ND; d++) check($sformatf("R2 pins dom%0d", d), 32'(pins(d)), 32'hB);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][73]) wr(VEC[v][72:64], VEC[v][63:32]);
      else rd_chk($sformatf("R%0d vector %0d", VEC[v][77:74], v), VEC[v][72:64], VEC[v][31:0]);
    end

    // R3 R5 R7: power-down of domain 0, S=2 F=2 -> 18 cycles
    wr(ad(0, 'h20), 32'd2);
    poll(0, 0, 200, n, tc, tr, ti, ts);
    check("R5 down duration", 32'(n), 32'd18);
    check("R3 order", 32'({tc < tr, tr < ti, ti < ts, tc == 1}), 32'hF);
    check("R3 pins off", 32'(pins(0)), 32'h4);
    rd_chk("R7 status off+done", ad(0, 'h24), 32'h0002_0002);
    rd_chk("R10 gates off", ad(0, 'h30), 32'h4);

    // R8 write-one-to-clear
    wr(ad(0, 'h24), 32'h0000_0008);
    rd_chk("R8 bit1 clear keeps done", ad(0, 'h24), 32'h0002_0002);
    wr(ad(0, 'h24), 32'h0000_0002);
    rd_chk("R8 w1c clears done", ad(0, 'h24), 32'h0002_0000);

    // R4 R9: power-up, second command while busy must not restart
    wr(ad(0, 'h20), 32'd1);
    wr(ad(0, 'h20), 32'd2);
    poll(0, 2, 200, n, tc, tr, ti, ts);
    check("R9 busy command ignored / R5 up duration", 32'(n), 32'd18);
    check("R4 order", 32'({ts < ti, ti < tr, tr < tc}), 32'h7);
    check("R4 pins on", 32'(pins(0)), 32'hB);
    rd_chk("R7 status on+done", ad(0, 'h24), 32'h0001_0002);

    // R9 invalid codes and same-state command
    wr(ad(0, 'h24), 32'h2);
    wr(ad(0, 'h20), 32'd3);
    wr(ad(0, 'h20), 32'd0);
    wr(ad(0, 'h20), 32'd1);
    rd_chk("R9 no transition", ad(0, 'h24), 32'h0001_0000);
    repeat (5) @(negedge clk);
    rd_chk("R9 still idle", ad(0, 'h24), 32'h0001_0000);
    check("R9 pins unchanged", 32'(pins(0)), 32'hB);

    // R5 zero delays on domain 1, R11 other domains untouched
    wr(ad(1, 'h14), 32'd0);
    wr(ad(1, 'h18), 32'd0);
    wr(ad(1, 'h1C), 32'd7);
    wr(ad(1, 'h20), 32'd2);
    poll(1, 0, 200, n, tc, tr, ti, ts);
    check("R5 zero-delay down", 32'(n), 32'd10);
    check("R11 dom0 pins", 32'(pins(0)), 32'hB);
    check("R11 dom2 pins", 32'(pins(2)), 32'hB);
    rd_chk("R11 dom0 status", ad(0, 'h24), 32'h0001_0000);
    wr(ad(1, 'h24), 32'h2);
    wr(ad(1, 'h20), 32'd1);
    poll(1, 0, 200, n, tc, tr, ti, ts);
    check("R5 up uses up delay", 32'(n), 32'd17);
    rd_chk("R7 dom1 on", ad(1, 'h24), 32'h0001_0002);

    // R6 switch acknowledge stall on domain 2
    ack_frz[2] = 1'b1; ack_val[2] = 1'b1;
    wr(ad(2, 'h20), 32'd2);
    poll(2, 0, 40, n, tc, tr, ti, ts);
    check("R6 stalled busy", 32'(bus_rd_data[3]), 32'd1);
    check("R6 switch driven", 32'(dom_pwr_sw[2]), 32'd0);
    bus_addr = ad(2, 'h34);
    #0.5;
    check("R10 switch status", bus_rd_data, 32'h1);
    ack_frz[2] = 1'b0;
    poll(2, 40, 200, n, tc, tr, ti, ts);
    check("R6 finish after ack", 32'(n), 32'd45);

    // R2 reset in the middle of a transition
    wr(ad(0, 'h20), 32'd2);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R2 pins after reset", 32'(pins(0)), 32'hB);
    rd_chk("R2 status after reset", ad(0, 'h24), 32'h0001_0000);
    rd_chk("R2 delay restored", ad(1, 'h14), 32'h2);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule